// File: doc/BRIEF.md
# Keyed Configuration Byte-Stream Window

This block is a memory-mapped slave through which boot firmware fetches configuration items. Firmware writes a 16-bit key into a selector register to choose an item. It then reads the item's bytes, or writes them, through a single 64-bit data window. The block keeps a byte position inside the selected item. Every access to the data window moves that position forward by the access width, so the window behaves as a byte stream. A multi-byte access carries consecutive item bytes on increasing byte lanes.

The register region is ten bytes long. The data window occupies offsets 0x0 to 0x7 and the selector occupies offsets 0x8 to 0x9. The item store holds four items:
- a fixed four-character identification string under key 0x0000;
- a 32-bit little-endian revision word under key 0x0001;
- a small writable byte array;
- a read-only byte array whose contents are computed.

Top module: `cfg_window`

## Requirements
- R1: After reset the selected key is 0x0000, the item position is 0 and `rsp_valid` is low. An 8-byte read at 0x0 right after reset returns the identification string.
- R2: A 2-byte write (`req_size`=1) at address 0x8 sets the key big-endian: write-data lane 0 (bits 7:0) is the key's upper byte and lane 1 (bits 15:8) is its lower byte.
- R3: A valid selector write resets the item position to 0.
- R4: Key 0x0000 yields the SIGNATURE parameter as four bytes. Its first character (bits 31:24 of the parameter) comes first.
- R5: Key 0x0001 yields the 4-byte REVISION parameter in little-endian order, with a default value of zero.
- R6: A data access at 0x0 with `req_size` n (0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes) covers 2^n bytes. Item byte position+j appears on lane j (bits 8j+7:8j), lanes at or above 2^n read as zero, and the position advances by 2^n.
- R7: Item bytes past the end of the item, and all bytes of an unknown key, read as 0x00.
- R8: Key KEY_RAM (default 0x0002) is a RAM_BYTES-byte writable item. Write-data lane j replaces item byte position+j.
- R9: Writes to read-only items, to unknown keys, or to positions past the end of the writable item change no stored byte.
- R10: The following accesses return zero read data and leave the item position unchanged: reads at 0x8, accesses at 0x1 to 0x7, at 0x9, or at 0xA and above, and selector writes whose size is not 2 bytes.
- R11: `req_ready` is always high. Every accepted request produces exactly one `rsp_valid` pulse in the next cycle, and write responses carry zero data.
- R12: Key KEY_ROM (default 0x0003) is a ROM_BYTES-byte read-only item whose byte i equals (7*i + 0x11) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | 4 | Byte offset inside the region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code: 2^n bytes |
| req_wdata | input | 64 | Write data, lane j in bits 8j+7:8j |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 64 | Read data for the accepted request |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- zero data on write responses and on lanes beyond the access width;
- zero data and a held item position for the off-window accesses;
- position clear after a selector write and the exact position advance on data accesses.

The actual byte values need the bench's model and scenarios. These cover the identification and revision contents, the big-endian key order, past-the-end zero fill, and the write-then-reread sequences that show writable bytes change while read-only ones do not.

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter logic [31:0] SIGNATURE = "BOOT",
  parameter logic [31:0] REVISION  = 32'h0000_0000,
  parameter int          RAM_BYTES = 16,
  parameter int          ROM_BYTES = 12,
  parameter logic [15:0] KEY_RAM   = 16'h0002,
  parameter logic [15:0] KEY_ROM   = 16'h0003,
  parameter int          OFF_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata
);
  localparam logic [15:0] KEY_SIG = 16'h0000;
  localparam logic [15:0] KEY_REV = 16'h0001;
  localparam logic [3:0]  ADDR_DATA = 4'h0;
  localparam logic [3:0]  ADDR_SEL  = 4'h8;
  localparam int          RAM_IW  = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [OFF_W:0] LEN_ID  = (OFF_W+1)'(4);
  localparam logic [OFF_W:0] LEN_RAM = (OFF_W+1)'(RAM_BYTES);
  localparam logic [OFF_W:0] LEN_ROM = (OFF_W+1)'(ROM_BYTES);

  logic [15:0]      key;
  logic [OFF_W-1:0] offset;
  logic [7:0]       ram [RAM_BYTES];
  logic [OFF_W:0]   item_len;
  logic [OFF_W:0]   pos [8];
  logic [7:0]       lane_on;
  logic [63:0]      rd_word;
  logic [3:0]       nbytes;
  logic [OFF_W:0]   off_sum;

  assign req_ready = 1'b1;
  wire acc      = req_valid && req_ready;
  wire data_hit = acc && req_addr == ADDR_DATA;
  wire sel_wr   = acc && req_write && req_addr == ADDR_SEL && req_size == 2'd1;
  wire ram_we   = data_hit && req_write && key == KEY_RAM;
  assign nbytes  = 4'd1 << req_size;
  assign off_sum = {1'b0, offset} + (OFF_W+1)'(nbytes);

  always_comb begin
    if (key == KEY_SIG || key == KEY_REV) item_len = LEN_ID;
    else if (key == KEY_RAM)              item_len = LEN_RAM;
    else if (key == KEY_ROM)              item_len = LEN_ROM;
    else                                  item_len = '0;
  end

  for (genvar j = 0; j < 8; j++) begin : g_lane
    logic [7:0] b;
    assign pos[j]     = {1'b0, offset} + (OFF_W+1)'(j);
    assign lane_on[j] = 4'(j) < nbytes;
    always_comb begin
      b = 8'h00;
      if (lane_on[j] && pos[j] < item_len) begin
        if (key == KEY_SIG)      b = 8'(SIGNATURE >> {2'd3 - pos[j][1:0], 3'b000});
        else if (key == KEY_REV) b = 8'(REVISION >> {pos[j][1:0], 3'b000});
        else if (key == KEY_RAM) b = ram[pos[j][RAM_IW-1:0]];
        else                     b = pos[j][7:0] * 8'd7 + 8'h11;
      end
    end
    assign rd_word[8*j +: 8] = b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key    <= KEY_SIG;
      offset <= '0;
    end else if (sel_wr) begin
      key    <= {req_wdata[7:0], req_wdata[15:8]};
      offset <= '0;
    end else if (data_hit) begin
      offset <= off_sum[OFF_W] ? '1 : off_sum[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= 8'h00;
    end else if (ram_we) begin
      for (int j = 0; j < 8; j++)
        if (lane_on[j] && pos[j] < LEN_RAM)
          ram[pos[j][RAM_IW-1:0]] <= req_wdata[8*j +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= (data_hit && !req_write) ? rd_word : '0;
    end
  end
endmodule

module cfg_window_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_addr,
  input logic             req_write,
  input logic [1:0]       req_size,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic [OFF_W-1:0] offset
);
  wire acc    = req_valid && req_ready;
  wire sel_ok = acc && req_write && req_addr == 4'h8 && req_size == 2'd1;

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  assert_write_rsp_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> rsp_rdata == 64'h0);
  assert_upper_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> (rsp_rdata >> (7'd8 << $past(req_size))) == 64'h0);
  assert_offwindow_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr != 4'h0 && !sel_ok) |=> (rsp_rdata == 64'h0 && offset == $past(offset)));
  assert_select_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |=> offset == '0);
  assert_data_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr == 4'h0 && offset[OFF_W-1:OFF_W-4] != 4'hF) |=>
      offset == $past(offset) + OFF_W'(4'd1 << $past(req_size)));
endmodule

bind cfg_window cfg_window_chk #(.OFF_W(OFF_W)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .offset(offset)
);

// File: tb/cfg_window_test.sv
`timescale 1ns/1ps
module cfg_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] mkey;
  int          moff;
  logic [7:0]  mram [16];

  always #2 clk = ~clk;

  cfg_window uut (.*);

  function automatic logic [7:0] exp_byte(logic [15:0] k, int p);
    logic [31:0] sig = "BOOT";
    if (k == 16'h0000 && p < 4) return sig[31-8*p -: 8];
    if (k == 16'h0001 && p < 4) return 8'h00;
    if (k == 16'h0002 && p < 16) return mram[p];
    if (k == 16'h0003 && p < 12) return 8'((p * 7 + 17) % 256);
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] a, bit w, logic [1:0] sz, logic [63:0] wd);
    logic [63:0] exp = '0;
    int n = 1 << sz;
    if (a == 4'h0 && !w)
      for (int j = 0; j < n; j++) exp[8*j +: 8] = exp_byte(mkey, moff + j);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, "/R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(tag, rsp_rdata, exp);
    if (a == 4'h0) begin
      if (w && mkey == 16'h0002)
        for (int j = 0; j < n; j++) if (moff + j < 16) mram[moff + j] = wd[8*j +: 8];
      moff += n;
    end else if (a == 4'h8 && w && sz == 2'd1) begin
      mkey = {wd[7:0], wd[15:8]};
      moff = 0;
    end
  endtask

  task automatic select(string tag, logic [15:0] k);
    step(tag, 4'h8, 1'b1, 2'd1, {48'h0, k[7:0], k[15:8]});
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd5150));
    mkey = 16'h0000; moff = 0;
    for (int i = 0; i < 16; i++) mram[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rsp_valid idle in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    step("R1 R4 read after reset", 4'h0, 1'b0, 2'd3, '0);
    check("R4 packed signature", 64'h0000_0000_544F_4F42, 64'h0000_0000_544F_4F42);
    select("R3 reselect sig", 16'h0000);
    for (int i = 0; i < 5; i++) step("R4 R6 R7 byte stream", 4'h0, 1'b0, 2'd0, '0);
    select("R5 sel rev", 16'h0001);
    step("R5 revision word", 4'h0, 1'b0, 2'd2, '0);
    step("R7 past end rev", 4'h0, 1'b0, 2'd1, '0);
    step("R2 big-endian key 0x0003", 4'h8, 1'b1, 2'd1, 64'h0300);
    step("R12 R6 rom 8B", 4'h0, 1'b0, 2'd3, '0);
    step("R12 R7 rom tail", 4'h0, 1'b0, 2'd3, '0);
    step("R2 swapped key 0x0300", 4'h8, 1'b1, 2'd1, 64'h0003);
    step("R7 unknown key", 4'h0, 1'b0, 2'd3, '0);
    step("R9 write unknown", 4'h0, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    select("R8 sel ram", 16'h0002);
    step("R8 write 8B", 4'h0, 1'b1, 2'd3, 64'h8877_6655_4433_2211);
    step("R8 write 4B", 4'h0, 1'b1, 2'd2, 64'h0000_0000_CCBB_AA99);
    step("R9 write past end", 4'h0, 1'b1, 2'd3, 64'h1111_2222_3333_4444);
    select("R3 reselect ram", 16'h0002);
    step("R8 readback lo", 4'h0, 1'b0, 2'd3, '0);
    step("R10 misaligned read", 4'h3, 1'b0, 2'd3, '0);
    step("R10 selector read", 4'h8, 1'b0, 2'd1, '0);
    step("R10 addr 0xC", 4'hC, 1'b1, 2'd3, 64'h5);
    step("R10 sel 1-byte write", 4'h8, 1'b1, 2'd0, 64'h01);
    step("R8 R9 readback hi", 4'h0, 1'b0, 2'd3, '0);
    select("R9 sel sig", 16'h0000);
    step("R9 write read-only", 4'h0, 1'b1, 2'd2, 64'h1234_5678);
    select("R9 reselect sig", 16'h0000);
    step("R9 R4 signature intact", 4'h0, 1'b0, 2'd2, '0);
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      logic [63:0] wd = {$urandom, $urandom};
      logic [1:0] sz = 2'($urandom_range(0, 3));
      if (op < 2) begin
        logic [15:0] k = ($urandom_range(0, 4) == 4) ? 16'($urandom) : 16'($urandom_range(0, 3));
        select("R2 R3 rand select", k);
      end else if (op < 6) step("R6 R7 R12 rand read", 4'h0, 1'b0, sz, '0);
      else if (op < 8) step("R8 R9 rand write", 4'h0, 1'b1, sz, wd);
      else step("R10 rand offwindow", 4'($urandom_range(1, 15)), 1'($urandom), sz,
                (wd & 64'hFFFF_FFFF_FFFF_FF00) | 64'h1);
    end
    finish_up();
  end
endmodule